// File: doc/BRIEF.md
# Standby Mode Controller with Wake Timer

This block manages the low-power states of a small microcontroller. Software programs a control byte that holds three settings: whether a SLEEP instruction enters light sleep or deep standby, a 3-bit code that picks how long to wait for the oscillator to settle after a deep-standby wake, and whether the external bus stays driven or floats while in standby. The core pulses `sleep_req` when it executes SLEEP, and the controller answers by gating the clock enables it hands to the core and to the on-chip peripherals.

In light sleep only the core clock stops. Any interrupt brings the core back on the next clock. In deep standby both clock enables drop and the bus outputs are either floated or frozen with the strobes forced inactive (high). Only the external interrupt ends deep standby. It starts a settling count, and both clock enables stay low until that count has run out. Every return to normal operation is marked by a one-cycle `wake_done` pulse.

The controller has five states. RUN is normal operation. SLEEP is light sleep. STBY is deep standby. SETTLE is the oscillator settling wait. WAKE is the single resume cycle. The transitions are:
- sleep-enter: RUN or WAKE to SLEEP.
- standby-enter: RUN or WAKE to STBY.
- sleep-wake: SLEEP to WAKE.
- standby-wake: STBY to SETTLE.
- settle-done: SETTLE to WAKE.
- resume: WAKE to RUN.

Top module: `pwrdn_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the controller is in RUN, both clock enables are high, `in_sleep`, `in_standby`, `wake_done` and `wsel_bad` are low, and the bus outputs follow the core with both output enables high.
- R2: The control byte places the standby-select bit at bit 7, the wait code at bits 6:4 and the bus-keep bit at bit 1. All other bits read 0 whatever is written to them.
- R3: A `sleep_req` pulse with bit 7 at 0 enters SLEEP: `cpu_clk_en` low, `periph_clk_en` high, `in_sleep` high. In SLEEP, `irq_any` or `ext_irq` high at a clock edge causes the next edge to show `wake_done` high with no settling wait.
- R4: A `sleep_req` pulse with bit 7 at 1 enters STBY, where both clock enables are low and `in_standby` is high. `irq_any` is ignored in STBY; only `ext_irq` leaves it.
- R5: The settling wait, counted in clock edges from the edge that samples `ext_irq` to the edge that raises `wake_done`, is 2^(B+code) for codes 0 to 5 and 2^(B-3) for code 6. B is the parameter `WAIT_BASE_LOG2`. With the default B=13 this gives 8192, 16384, 32768, 65536, 131072, 262144 and 1024.
- R6: Code 7 is treated as the longest wait, 2^(B+5). Writing code 7 sets `wsel_bad`, which then stays high until reset, even after a legal code is written.
- R7: Both clock enables stay low for the whole settling wait. `wake_done` is high for exactly one cycle, during which both clock enables are high.
- R8: Bit 7 still reads 1 after a deep-standby wake. Only a write of 0 clears it.
- R9: With bit 1 at 0, `bus_addr_oe` and `bus_ctl_oe` are low throughout STBY and SETTLE.
- R10: With bit 1 at 1, during STBY and SETTLE `bus_addr` holds the `core_addr` value presented with the entering `sleep_req`, `bus_ctl` is all ones, and both output enables are high.
- R11: In RUN, WAKE and SLEEP, `bus_addr` equals `core_addr` and `bus_ctl` equals `core_ctl`, with both output enables high.
- R12: When a register write and `sleep_req` fall in the same cycle, the mode is chosen by the bit 7 value held before the write. The write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Control byte write strobe |
| reg_wdata | input | 8 | Control byte write data |
| reg_rdata | output | 8 | Control byte readback |
| wsel_bad | output | 1 | Sticky flag: illegal wait code was written |
| sleep_req | input | 1 | Pulse from the core: SLEEP executed |
| irq_any | input | 1 | Any pending interrupt (light-sleep wake) |
| ext_irq | input | 1 | External interrupt (standby wake) |
| cpu_clk_en | output | 1 | Core clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| in_sleep | output | 1 | Controller is in SLEEP |
| in_standby | output | 1 | Controller is in STBY |
| wake_done | output | 1 | One-cycle pulse on return to operation |
| core_addr | input | AW | Address from the core |
| core_ctl | input | CW | Active-low bus strobes from the core |
| bus_addr | output | AW | Address to the pins |
| bus_addr_oe | output | 1 | Address output enable |
| bus_ctl | output | CW | Bus strobes to the pins |
| bus_ctl_oe | output | 1 | Strobe output enable |

## Verification
The bench provokes two same-cycle collisions.

The first is a control-byte write that lands on the same edge as `sleep_req` and flips the standby-select bit. The bench judges it by checking that the mode taken follows the old bit value. It then reads back the byte to confirm that the new value was stored.

The second is `irq_any` held high while in deep standby, a condition under which light sleep would wake. The bench judges it by checking that the controller stays in STBY with both clock enables low until `ext_irq` arrives.

// File: rtl/pwrdn_pkg.sv
package pwrdn_pkg;

    typedef enum logic [2:0] {
        PD_RUN    = 3'd0,
        PD_SLEEP  = 3'd1,
        PD_STBY   = 3'd2,
        PD_SETTLE = 3'd3,
        PD_WAKE   = 3'd4
    } pd_state_t;

    localparam int unsigned CTRL_W    = 8;
    localparam int unsigned BIT_SBY   = 7;
    localparam int unsigned WSEL_LSB  = 4;
    localparam int unsigned WSEL_W    = 3;
    localparam int unsigned BIT_KEEP  = 1;
    localparam logic [2:0]  WSEL_SHORT = 3'd6;
    localparam logic [2:0]  WSEL_ILL   = 3'd7;

    // settle length in clock edges for a wait code, given log2 of the base wait
    function automatic int unsigned settle_len(input logic [2:0] code, input int unsigned base_log2);
        int unsigned len;
        if (code == WSEL_SHORT)
            len = 32'd1 << (base_log2 - 3);
        else if (code == WSEL_ILL)
            len = 32'd1 << (base_log2 + 5);
        else
            len = 32'd1 << (base_log2 + int'(code));
        return len;
    endfunction

endpackage

// File: rtl/pwrdn_cfg_reg.sv
module pwrdn_cfg_reg
    import pwrdn_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr,
    input  logic [CTRL_W-1:0]    wdata,
    output logic [CTRL_W-1:0]    rdata,
    output logic                 sby_sel,
    output logic [WSEL_W-1:0]    wsel,
    output logic                 bus_keep,
    output logic                 bad_code
);

    logic                 sby_q;
    logic [WSEL_W-1:0]    wsel_q;
    logic                 keep_q;
    logic                 bad_q;
    logic                 unused_wbits;

    assign unused_wbits = ^{wdata[3:2], wdata[0]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sby_q  <= 1'b0;
            wsel_q <= '0;
            keep_q <= 1'b0;
        end else if (wr) begin
            sby_q  <= wdata[BIT_SBY];
            wsel_q <= wdata[WSEL_LSB +: WSEL_W];
            keep_q <= wdata[BIT_KEEP];
        end
    end

    // sticky record of an illegal wait code; only reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bad_q <= 1'b0;
        else if (wr && (wdata[WSEL_LSB +: WSEL_W] == WSEL_ILL))
            bad_q <= 1'b1;
    end

    always_comb begin
        rdata                       = '0;
        rdata[BIT_SBY]              = sby_q;
        rdata[WSEL_LSB +: WSEL_W]   = wsel_q;
        rdata[BIT_KEEP]             = keep_q;
    end

    assign sby_sel  = sby_q;
    assign wsel     = wsel_q;
    assign bus_keep = keep_q;
    assign bad_code = bad_q;

endmodule

// File: rtl/pwrdn_wait_timer.sv
module pwrdn_wait_timer #(
    parameter int unsigned CNT_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    // load len-1 so that the caller spends exactly len cycles waiting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= len - CNT_W'(1);
        else if (cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/pwrdn_bus_hold.sv
module pwrdn_bus_hold #(
    parameter int unsigned AW = 24,
    parameter int unsigned CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          freeze,
    input  logic          keep,
    input  logic [AW-1:0] core_addr,
    input  logic [CW-1:0] core_ctl,
    output logic [AW-1:0] pin_addr,
    output logic          pin_addr_oe,
    output logic [CW-1:0] pin_ctl,
    output logic          pin_ctl_oe
);

    logic [AW-1:0] addr_q;

    // track the core address while running; stop tracking once frozen
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            addr_q <= '0;
        else if (!freeze)
            addr_q <= core_addr;
    end

    always_comb begin
        if (freeze) begin
            pin_addr    = addr_q;
            pin_ctl     = '1;
            pin_addr_oe = keep;
            pin_ctl_oe  = keep;
        end else begin
            pin_addr    = core_addr;
            pin_ctl     = core_ctl;
            pin_addr_oe = 1'b1;
            pin_ctl_oe  = 1'b1;
        end
    end

endmodule

// File: rtl/pwrdn_ctrl.sv
module pwrdn_ctrl
    import pwrdn_pkg::*;
#(
    parameter int unsigned AW             = 24,
    parameter int unsigned CW             = 8,
    parameter int unsigned WAIT_BASE_LOG2 = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [CTRL_W-1:0]    reg_wdata,
    output logic [CTRL_W-1:0]    reg_rdata,
    output logic                 wsel_bad,
    input  logic                 sleep_req,
    input  logic                 irq_any,
    input  logic                 ext_irq,
    output logic                 cpu_clk_en,
    output logic                 periph_clk_en,
    output logic                 in_sleep,
    output logic                 in_standby,
    output logic                 wake_done,
    input  logic [AW-1:0]        core_addr,
    input  logic [CW-1:0]        core_ctl,
    output logic [AW-1:0]        bus_addr,
    output logic                 bus_addr_oe,
    output logic [CW-1:0]        bus_ctl,
    output logic                 bus_ctl_oe
);

    localparam int unsigned CNT_W = WAIT_BASE_LOG2 + 6;

    pd_state_t          state_q, state_d;
    logic               sby_sel;
    logic [WSEL_W-1:0]  wsel;
    logic               bus_keep;
    logic               tmr_load;
    logic               tmr_expired;
    logic [CNT_W-1:0]   tmr_len;
    logic               freeze;

    pwrdn_cfg_reg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .sby_sel  (sby_sel),
        .wsel     (wsel),
        .bus_keep (bus_keep),
        .bad_code (wsel_bad)
    );

    assign tmr_len = CNT_W'(settle_len(wsel, WAIT_BASE_LOG2));

    pwrdn_wait_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .len     (tmr_len),
        .expired (tmr_expired)
    );

    pwrdn_bus_hold #(.AW(AW), .CW(CW)) u_bus (
        .clk         (clk),
        .rst_n       (rst_n),
        .freeze      (freeze),
        .keep        (bus_keep),
        .core_addr   (core_addr),
        .core_ctl    (core_ctl),
        .pin_addr    (bus_addr),
        .pin_addr_oe (bus_addr_oe),
        .pin_ctl     (bus_ctl),
        .pin_ctl_oe  (bus_ctl_oe)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= PD_RUN;
        else
            state_q <= state_d;
    end

    // next state and timer load
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        unique case (state_q)
            PD_RUN, PD_WAKE: begin
                if (sleep_req)
                    state_d = sby_sel ? PD_STBY : PD_SLEEP;
                else
                    state_d = PD_RUN;
            end
            PD_SLEEP: begin
                if (irq_any || ext_irq)
                    state_d = PD_WAKE;
            end
            PD_STBY: begin
                if (ext_irq) begin
                    state_d  = PD_SETTLE;
                    tmr_load = 1'b1;
                end
            end
            PD_SETTLE: begin
                if (tmr_expired)
                    state_d = PD_WAKE;
            end
            default: state_d = PD_RUN;
        endcase
    end

    // outputs
    always_comb begin
        cpu_clk_en    = 1'b1;
        periph_clk_en = 1'b1;
        in_sleep      = 1'b0;
        in_standby    = 1'b0;
        wake_done     = 1'b0;
        freeze        = 1'b0;
        unique case (state_q)
            PD_RUN: ;
            PD_WAKE: wake_done = 1'b1;
            PD_SLEEP: begin
                cpu_clk_en = 1'b0;
                in_sleep   = 1'b1;
            end
            PD_STBY: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                in_standby    = 1'b1;
                freeze        = 1'b1;
            end
            PD_SETTLE: begin
                cpu_clk_en    = 1'b0;
                periph_clk_en = 1'b0;
                freeze        = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/pwrdn_ctrl_chk.sv
module pwrdn_ctrl_chk #(
    parameter int unsigned AW = 24,
    parameter int unsigned CW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [7:0]    reg_rdata,
    input logic          wsel_bad,
    input logic          irq_any,
    input logic          ext_irq,
    input logic          cpu_clk_en,
    input logic          periph_clk_en,
    input logic          in_sleep,
    input logic          in_standby,
    input logic          wake_done,
    input logic [AW-1:0] bus_addr,
    input logic          bus_addr_oe,
    input logic [CW-1:0] bus_ctl,
    input logic          bus_ctl_oe
);

    a_r3_sleep_wakes_next: assert property (@(posedge clk) disable iff (!rst_n)
        (in_sleep && (irq_any || ext_irq)) |=> wake_done);

    a_r4_standby_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !ext_irq) |=> in_standby);

    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        wsel_bad |=> wsel_bad);

    a_r7_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |=> !wake_done);

    a_r7_wake_clocks_on: assert property (@(posedge clk) disable iff (!rst_n)
        wake_done |-> (cpu_clk_en && periph_clk_en));

    a_r9_float_in_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (in_standby && !reg_rdata[1]) |-> (!bus_addr_oe && !bus_ctl_oe));

    a_r10_strobes_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_clk_en && bus_ctl_oe) |-> (bus_ctl == {CW{1'b1}}));

    a_r10_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!periph_clk_en && $past(!periph_clk_en) && bus_addr_oe) |-> $stable(bus_addr));

endmodule

bind pwrdn_ctrl pwrdn_ctrl_chk #(.AW(AW), .CW(CW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .reg_rdata     (reg_rdata),
    .wsel_bad      (wsel_bad),
    .irq_any       (irq_any),
    .ext_irq       (ext_irq),
    .cpu_clk_en    (cpu_clk_en),
    .periph_clk_en (periph_clk_en),
    .in_sleep      (in_sleep),
    .in_standby    (in_standby),
    .wake_done     (wake_done),
    .bus_addr      (bus_addr),
    .bus_addr_oe   (bus_addr_oe),
    .bus_ctl       (bus_ctl),
    .bus_ctl_oe    (bus_ctl_oe)
);

// File: tb/pwrdn_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwrdn_ctrl_tb_top;

    localparam int unsigned AW = 8;
    localparam int unsigned CW = 4;
    localparam int unsigned B  = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          reg_wr = 1'b0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          wsel_bad;
    logic          sleep_req = 1'b0;
    logic          irq_any = 1'b0;
    logic          ext_irq = 1'b0;
    logic          cpu_clk_en, periph_clk_en, in_sleep, in_standby, wake_done;
    logic [AW-1:0] core_addr = '0;
    logic [CW-1:0] core_ctl = '0;
    logic [AW-1:0] bus_addr;
    logic          bus_addr_oe;
    logic [CW-1:0] bus_ctl;
    logic          bus_ctl_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    pwrdn_ctrl #(.AW(AW), .CW(CW), .WAIT_BASE_LOG2(B)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .wsel_bad(wsel_bad), .sleep_req(sleep_req),
        .irq_any(irq_any), .ext_irq(ext_irq), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .in_sleep(in_sleep), .in_standby(in_standby),
        .wake_done(wake_done), .core_addr(core_addr), .core_ctl(core_ctl),
        .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe), .bus_ctl(bus_ctl),
        .bus_ctl_oe(bus_ctl_oe)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_wait(input int code);
        if (code == 6) return 1 << (B - 3);
        if (code == 7) return 1 << (B + 5);
        return 1 << (B + code);
    endfunction

    task automatic wr(input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic pulse_sleep();
        @(negedge clk); sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    // R4, R5, R7, R9, R10: deep standby round trip with a given wait code and keep bit
    task automatic standby_trip(input int code, input bit keep, input string tag);
        int n;
        int gate_bad;
        logic [AW-1:0] held;
        held = AW'(8'hA0 + code);
        wr({1'b1, 3'(code), 2'b00, keep, 1'b0});
        @(negedge clk); core_addr = held; core_ctl = 4'h3; sleep_req = 1'b1;
        @(negedge clk); sleep_req = 1'b0; core_addr = 8'h11; core_ctl = 4'h0;
        chk({tag, " R4 in_standby"}, in_standby, 1);
        chk({tag, " R4 clocks gated"}, {cpu_clk_en, periph_clk_en}, 0);
        if (keep) begin
            chk({tag, " R10 addr held"}, bus_addr, held);
            chk({tag, " R10 strobes high"}, bus_ctl, 4'hF);
            chk({tag, " R10 oe"}, {bus_addr_oe, bus_ctl_oe}, 2'b11);
        end else begin
            chk({tag, " R9 floated"}, {bus_addr_oe, bus_ctl_oe}, 0);
        end
        irq_any = 1'b1;
        repeat (3) @(negedge clk);
        irq_any = 1'b0;
        chk({tag, " R4 irq_any ignored"}, {in_standby, cpu_clk_en, periph_clk_en}, 3'b100);
        ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
        n = 0; gate_bad = 0;
        while (!wake_done && n < 5000) begin
            if (cpu_clk_en || periph_clk_en) gate_bad++;
            if (keep && bus_addr != held) gate_bad++;
            @(negedge clk);
            n++;
        end
        chk({tag, " R5 wait length"}, n, exp_wait(code));
        chk({tag, " R7 gated during settle"}, gate_bad, 0);
        chk({tag, " R7 clocks on at wake"}, {cpu_clk_en, periph_clk_en}, 2'b11);
        @(negedge clk);
        chk({tag, " R7 wake_done one cycle"}, wake_done, 0);
        chk({tag, " R8 standby bit kept"}, reg_rdata[7], 1);
        chk({tag, " R11 pass-through after wake"}, bus_addr, 8'h11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        core_addr = 8'h5A; core_ctl = 4'h6;
        @(negedge clk);
        // R1
        chk("R1 rdata", reg_rdata, 0);
        chk("R1 flags", {cpu_clk_en, periph_clk_en, in_sleep, in_standby, wake_done, wsel_bad}, 6'b110000);
        chk("R1 bus", {bus_addr, bus_ctl, bus_addr_oe, bus_ctl_oe}, {8'h5A, 4'h6, 2'b11});

        // R2: unused bits read 0
        wr(8'h5E);
        chk("R2 layout 0x5E", reg_rdata, 8'h52);
        wr(8'hAD);
        chk("R2 layout 0xAD", reg_rdata, 8'hA0);
        wr(8'h00);

        // R3, R11: light sleep, woken by irq_any
        pulse_sleep();
        chk("R3 sleep state", {in_sleep, in_standby, cpu_clk_en, periph_clk_en}, 4'b1001);
        core_addr = 8'h3C; core_ctl = 4'h9;
        @(negedge clk);
        chk("R11 pass-through in sleep", {bus_addr, bus_ctl, bus_addr_oe, bus_ctl_oe}, {8'h3C, 4'h9, 2'b11});
        irq_any = 1'b1;
        @(negedge clk); irq_any = 1'b0;
        chk("R3 wake next clock", {wake_done, in_sleep, cpu_clk_en}, 3'b101);
        @(negedge clk);
        chk("R3 pulse ends", wake_done, 0);

        // R3: light sleep woken by ext_irq
        pulse_sleep();
        ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
        chk("R3 ext wake from sleep", {wake_done, in_sleep}, 2'b10);

        // R4, R5, R7, R8, R9, R10: sweep of all legal codes, alternating keep bit
        for (int c = 0; c < 7; c++) begin
            standby_trip(c, c[0], $sformatf("code%0d", c));
        end

        // R8: write 0 clears standby select
        wr(8'h00);
        chk("R8 cleared by write", reg_rdata[7], 0);

        // R12: write and sleep_req collide; old bit decides
        @(negedge clk); reg_wr = 1'b1; reg_wdata = 8'h80; sleep_req = 1'b1;
        @(negedge clk); reg_wr = 1'b0; sleep_req = 1'b0;
        chk("R12 old bit picks sleep", {in_sleep, in_standby}, 2'b10);
        chk("R12 write stored", reg_rdata, 8'h80);
        irq_any = 1'b1;
        @(negedge clk); irq_any = 1'b0;
        @(negedge clk);
        pulse_sleep();
        chk("R12 next sleep is standby", {in_sleep, in_standby}, 2'b01);
        ext_irq = 1'b1;
        @(negedge clk); ext_irq = 1'b0;
        begin
            int n = 0;
            while (!wake_done && n < 5000) begin @(negedge clk); n++; end
            chk("R12 R5 code0 wait", n, exp_wait(0));
        end
        @(negedge clk);

        // R6: illegal code
        chk("R6 flag clear before", wsel_bad, 0);
        standby_trip(7, 1'b1, "code7 R6");
        chk("R6 flag set", wsel_bad, 1);
        wr(8'h80);
        chk("R6 flag sticky", wsel_bad, 1);
        do_reset();
        chk("R6 flag cleared by reset", wsel_bad, 0);
        chk("R1 rdata after reset", reg_rdata, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule